// File: doc/BRIEF.md
# Multi-Wide Reorder Buffer

This block keeps the program order of in-flight instructions in an out-of-order core. Rename hands it a bundle of up to WIDTH instructions in each cycle. Each instruction carries an architectural destination register and a flag that says whether it writes one. The block places the whole bundle in consecutive slots of a circular buffer. It returns each slot index as a tag, and later pipeline stages use that tag as the rename tag. The buffer can also refuse the whole bundle.

Execution units report completion by presenting a tag on one of WB_PORTS writeback ports, and that slot becomes ready. At the oldest end, up to WIDTH slots leave per cycle, strictly oldest first. The retire stream stops at the first slot that has not completed. The retire stream reports each leaving slot's tag and destination so that the mapping table can release it. DEPTH must be a power of two.

Back-pressure rules:
- Allocate side:
  - A bundle transfers on a clock edge where `alloc_valid` and `alloc_ready` are both high.
  - `alloc_ready` depends only on `alloc_num` and on the occupancy at the start of the cycle.
- Retire side:
  - `ret_valid` never depends on `ret_ready`.
  - The offered lanes leave on the edge where `ret_ready` is high.
  - While `ret_ready` is low, the offer is held.

Top module: `multiwide_rob`

## Requirements
- R1: After reset the buffer is empty: `ret_valid` is all zero, `alloc_ready` is high for a bundle of WIDTH, and the first bundle receives tags 0, 1, … in lanes 0, 1, ….
- R2: An accepted bundle of N entries (lanes 0..N-1 of `alloc_dst`/`alloc_has_dst`) gets consecutive tags starting at the tail. The tag for lane i sits at `alloc_tag[i*TAG_W +: TAG_W]`, and tags wrap modulo DEPTH.
- R3: `alloc_ready` is low whenever fewer than `alloc_num` slots are free. A refused bundle claims no slot at all, and the next accepted bundle starts at the same tail.
- R4: A tag presented on any writeback port in cycle t makes that slot eligible to retire from cycle t+1. Several ports may report in the same cycle.
- R5: `ret_valid` bit i (lane 0 the oldest) is set only if the slots at head..head+i are all occupied and ready. The set bits always form a run starting at lane 0, and lane i reports tag head+i.
- R6: For each offered lane, `ret_dst` and `ret_has_dst` return the destination and the writes-a-register flag stored at allocation. A flag of 0 means the entry writes no register.
- R7: While `ret_ready` is low, no slot leaves and the offered tags stay unchanged.
- R8: Full is told apart from empty: after DEPTH slots are allocated with none retired, a bundle of even one entry is refused.
- R9: Slots that retire on an edge can be allocated from the next cycle on. Free space is measured at the start of the cycle, so retirement in the same cycle does not count toward it.
- R10: An accepted bundle with `alloc_num` of 0 allocates nothing and leaves the tail where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Rename bundle present |
| alloc_ready | output | 1 | Enough free slots for the whole bundle |
| alloc_num | input | $clog2(WIDTH+1) | Number of entries in the bundle, lanes 0 upward |
| alloc_dst | input | WIDTH*7 | Destination register per lane |
| alloc_has_dst | input | WIDTH | Lane writes a register |
| alloc_tag | output | WIDTH*TAG_W | Tag given to each lane |
| wb_valid | input | WB_PORTS | Completion report per port |
| wb_tag | input | WB_PORTS*TAG_W | Completing tag per port |
| ret_valid | output | WIDTH | Lanes offered for retirement, prefix from lane 0 |
| ret_ready | input | 1 | Consumer takes the offered lanes |
| ret_tag | output | WIDTH*TAG_W | Tag per retire lane |
| ret_dst | output | WIDTH*7 | Destination register per retire lane |
| ret_has_dst | output | WIDTH | Retire lane writes a register |

## Verification
The bench fills the buffer across the wrap of the tail and asks for one more entry. A design that confuses full with empty would accept that entry and hand out a tag that is still live. Completions arrive out of order with a gap at the head. A retire stage that skipped non-ready slots would offer lanes past the gap or report tags out of order. A bundle is refused for lack of space and then retried. A design that allocated part of a bundle would return a later starting tag on the retry. The bench also drops `ret_ready`, sends two completions in the same cycle, and resets in the middle of a run. Each of these would expose a lost commit, a lost completion, or stale state.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int ARCH_REG_W = 7;

  typedef struct packed {
    logic                  has_dst;
    logic [ARCH_REG_W-1:0] dst;
  } rob_payload_t;

  localparam int PAY_W = $bits(rob_payload_t);
endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NUM_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic [NUM_W-1:0] alloc_num,
  input  logic [NUM_W-1:0] commit_num,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] free_slots
);
  logic [NUM_W-1:0] add_num;

  assign add_num    = alloc_fire ? alloc_num : '0;
  assign free_slots = CNT_W'(DEPTH) - count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head + TAG_W'(commit_num);
      tail  <= tail + TAG_W'(add_num);
      count <= count + CNT_W'(add_num) - CNT_W'(commit_num);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R8

  AST_COMMIT_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(commit_num) <= count); // R5
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store
  import rob_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4,
  parameter int WB_PORTS = 4,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int NUM_W = $clog2(WIDTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_fire,
  input  logic [TAG_W-1:0]          tail,
  input  logic [NUM_W-1:0]          alloc_num,
  input  logic [WIDTH*PAY_W-1:0]    alloc_pay,
  input  logic [WB_PORTS-1:0]       wb_valid,
  input  logic [WB_PORTS*TAG_W-1:0] wb_tag,
  input  logic [TAG_W-1:0]          head,
  output logic [DEPTH-1:0]          ready_vec,
  output logic [WIDTH*PAY_W-1:0]    head_pay
);
  logic [DEPTH-1:0]            wr_hit;
  logic [DEPTH-1:0]            wb_hit;
  logic [DEPTH-1:0][PAY_W-1:0] wr_pay;
  logic [DEPTH-1:0][PAY_W-1:0] pay_q;
  logic [DEPTH-1:0]            ready_q;

  always_comb begin
    wr_hit = '0;
    wb_hit = '0;
    wr_pay = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (alloc_fire && (NUM_W'(i) < alloc_num)) begin
        wr_hit[tail + TAG_W'(i)] = 1'b1;
        wr_pay[tail + TAG_W'(i)] = alloc_pay[i*PAY_W +: PAY_W];
      end
    end
    for (int p = 0; p < WB_PORTS; p++) begin
      if (wb_valid[p]) wb_hit[wb_tag[p*TAG_W +: TAG_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= '0;
      pay_q   <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (wr_hit[e]) begin
          ready_q[e] <= 1'b0;
          pay_q[e]   <= wr_pay[e];
        end else if (wb_hit[e]) begin
          ready_q[e] <= 1'b1;
        end
      end
    end
  end

  assign ready_vec = ready_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_rd
    assign head_pay[i*PAY_W +: PAY_W] = pay_q[head + TAG_W'(i)];
  end

  AST_WB_MARKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid[0] && !wr_hit[wb_tag[TAG_W-1:0]]) |=> ready_q[$past(wb_tag[TAG_W-1:0])]); // R4
endmodule

// File: rtl/rob_commit_sel.sv
module rob_commit_sel #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NUM_W = $clog2(WIDTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TAG_W-1:0]       head,
  input  logic [CNT_W-1:0]       count,
  input  logic [DEPTH-1:0]       ready_vec,
  output logic [WIDTH-1:0]       ret_mask,
  output logic [NUM_W-1:0]       ret_num,
  output logic [WIDTH*TAG_W-1:0] ret_tag
);
  always_comb begin
    logic               run;
    logic [TAG_W-1:0]   idx;
    run      = 1'b1;
    ret_mask = '0;
    ret_num  = '0;
    ret_tag  = '0;
    for (int i = 0; i < WIDTH; i++) begin
      idx = head + TAG_W'(i);
      ret_tag[i*TAG_W +: TAG_W] = idx;
      if (run && (CNT_W'(i) < count) && ready_vec[idx]) begin
        ret_mask[i] = 1'b1;
        ret_num     = ret_num + NUM_W'(1);
      end else begin
        run = 1'b0;
      end
    end
  end

  AST_RET_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_mask + WIDTH'(1)) & ret_mask) == '0); // R5

  AST_EMPTY_NO_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (ret_mask == '0)); // R5
endmodule

// File: rtl/multiwide_rob.sv
module multiwide_rob
  import rob_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4,
  parameter int WB_PORTS = 4,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NUM_W = $clog2(WIDTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  output logic                      alloc_ready,
  input  logic [NUM_W-1:0]          alloc_num,
  input  logic [WIDTH*ARCH_REG_W-1:0] alloc_dst,
  input  logic [WIDTH-1:0]          alloc_has_dst,
  output logic [WIDTH*TAG_W-1:0]    alloc_tag,
  input  logic [WB_PORTS-1:0]       wb_valid,
  input  logic [WB_PORTS*TAG_W-1:0] wb_tag,
  output logic [WIDTH-1:0]          ret_valid,
  input  logic                      ret_ready,
  output logic [WIDTH*TAG_W-1:0]    ret_tag,
  output logic [WIDTH*ARCH_REG_W-1:0] ret_dst,
  output logic [WIDTH-1:0]          ret_has_dst
);
  logic [TAG_W-1:0]       head, tail;
  logic [CNT_W-1:0]       count, free_slots;
  logic [NUM_W-1:0]       ret_num, commit_num;
  logic [DEPTH-1:0]       ready_vec;
  logic [WIDTH*PAY_W-1:0] alloc_pay, head_pay;
  logic                   alloc_fire;

  assign alloc_ready = free_slots >= CNT_W'(alloc_num);
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign commit_num  = ret_ready ? ret_num : '0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    rob_payload_t in_p, out_p;
    assign in_p.dst     = alloc_dst[i*ARCH_REG_W +: ARCH_REG_W];
    assign in_p.has_dst = alloc_has_dst[i];
    assign alloc_pay[i*PAY_W +: PAY_W] = in_p;
    assign alloc_tag[i*TAG_W +: TAG_W] = tail + TAG_W'(i);
    assign out_p = head_pay[i*PAY_W +: PAY_W];
    assign ret_dst[i*ARCH_REG_W +: ARCH_REG_W] = out_p.dst;
    assign ret_has_dst[i] = out_p.has_dst;
  end

  rob_ptr_ctl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_ptr (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .alloc_num(alloc_num),
    .commit_num(commit_num), .head(head), .tail(tail), .count(count),
    .free_slots(free_slots)
  );

  rob_entry_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .WB_PORTS(WB_PORTS)) i_store (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .tail(tail),
    .alloc_num(alloc_num), .alloc_pay(alloc_pay), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .head(head), .ready_vec(ready_vec), .head_pay(head_pay)
  );

  rob_commit_sel #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_sel (
    .clk(clk), .rst_n(rst_n), .head(head), .count(count), .ready_vec(ready_vec),
    .ret_mask(ret_valid), .ret_num(ret_num), .ret_tag(ret_tag)
  );

  AST_STALL_KEEPS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready) |=> $stable(tail)); // R3

  AST_ZERO_BUNDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_num == '0) |=> $stable(tail)); // R10

  AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid[0] && !ret_ready) |=> (ret_valid[0] && $stable(ret_tag))); // R7

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && alloc_num != '0) |-> !alloc_ready); // R8
endmodule

// File: tb/test_multiwide_rob.sv
module test_multiwide_rob;
  localparam int DEPTH = 16;
  localparam int WIDTH = 4;
  localparam int WBP   = 2;
  localparam int TW    = 4;
  localparam int RW    = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0;
  logic alloc_ready;
  logic [2:0] alloc_num = '0;
  logic [WIDTH*RW-1:0] alloc_dst = '0;
  logic [WIDTH-1:0] alloc_has_dst = '0;
  logic [WIDTH*TW-1:0] alloc_tag;
  logic [WBP-1:0] wb_valid = '0;
  logic [WBP*TW-1:0] wb_tag = '0;
  logic [WIDTH-1:0] ret_valid;
  logic ret_ready = 1'b0;
  logic [WIDTH*TW-1:0] ret_tag;
  logic [WIDTH*RW-1:0] ret_dst;
  logic [WIDTH-1:0] ret_has_dst;

  int checks = 0;
  int errors = 0;
  logic [TW-1:0] btail = '0;
  logic [TW-1:0] bhead = '0;

  always #4 clk = ~clk;

  multiwide_rob #(.DEPTH(DEPTH), .WIDTH(WIDTH), .WB_PORTS(WBP)) i_multiwide_rob (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_num(alloc_num), .alloc_dst(alloc_dst), .alloc_has_dst(alloc_has_dst),
    .alloc_tag(alloc_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_tag(ret_tag),
    .ret_dst(ret_dst), .ret_has_dst(ret_has_dst)
  );

  function automatic logic [RW-1:0] dst_of(logic [TW-1:0] t);
    return RW'((int'(t) * 5 + 1) % 67);
  endfunction

  function automatic logic has_of(logic [TW-1:0] t);
    return (int'(t) % 3) != 0;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_bundle(logic v, logic [2:0] n);
    alloc_valid = v;
    alloc_num   = n;
    for (int i = 0; i < WIDTH; i++) begin
      alloc_dst[i*RW +: RW] = dst_of(btail + TW'(i));
      alloc_has_dst[i]      = has_of(btail + TW'(i));
    end
  endtask

  // fields: a_val[14] a_num[13:11] wb_en[10] wb_tag[9:6] r_rdy[5] e_ardy[4] e_rmask[3:0]
  localparam logic [14:0] VEC [18] = '{
    {1'b1, 3'd4, 1'b0, 4'd0, 1'b1, 1'b1, 4'b0000},
    {1'b1, 3'd4, 1'b1, 4'd1, 1'b1, 1'b1, 4'b0000},
    {1'b1, 3'd0, 1'b1, 4'd0, 1'b1, 1'b1, 4'b0000},
    {1'b0, 3'd0, 1'b0, 4'd0, 1'b0, 1'b1, 4'b0011},
    {1'b0, 3'd0, 1'b0, 4'd0, 1'b1, 1'b1, 4'b0011},
    {1'b0, 3'd0, 1'b1, 4'd3, 1'b1, 1'b1, 4'b0000},
    {1'b0, 3'd0, 1'b1, 4'd2, 1'b1, 1'b1, 4'b0000},
    {1'b1, 3'd4, 1'b0, 4'd0, 1'b1, 1'b1, 4'b0011},
    {1'b1, 3'd4, 1'b0, 4'd0, 1'b1, 1'b1, 4'b0000},
    {1'b1, 3'd4, 1'b0, 4'd0, 1'b1, 1'b1, 4'b0000},
    {1'b1, 3'd1, 1'b0, 4'd0, 1'b1, 1'b0, 4'b0000},
    {1'b1, 3'd1, 1'b1, 4'd4, 1'b0, 1'b0, 4'b0000},
    {1'b1, 3'd1, 1'b1, 4'd5, 1'b0, 1'b0, 4'b0001},
    {1'b1, 3'd1, 1'b1, 4'd6, 1'b0, 1'b0, 4'b0011},
    {1'b1, 3'd1, 1'b1, 4'd7, 1'b0, 1'b0, 4'b0111},
    {1'b1, 3'd1, 1'b0, 4'd0, 1'b1, 1'b0, 4'b1111},
    {1'b1, 3'd4, 1'b0, 4'd0, 1'b1, 1'b1, 4'b0000},
    {1'b0, 3'd0, 1'b0, 4'd0, 1'b1, 1'b1, 4'b0000}
  };

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    drive_bundle(1'b0, 3'd4);
    #2;
    chk("R1", "alloc_ready", alloc_ready, 1'b1);
    chk("R1", "ret_valid", ret_valid, '0);
    chk("R1", "alloc_tag", alloc_tag, {4'd3, 4'd2, 4'd1, 4'd0});

    // Vector walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    // (R8 at rows 10-15, R9 at row 16, R10 at row 2, R7 at rows 3 and 11-14)
    for (int v = 0; v < 18; v++) begin
      @(negedge clk);
      drive_bundle(VEC[v][14], VEC[v][13:11]);
      wb_valid  = {1'b0, VEC[v][10]};
      wb_tag    = {4'd0, VEC[v][9:6]};
      ret_ready = VEC[v][5];
      #2;
      chk("R3/R8", $sformatf("alloc_ready row %0d", v), alloc_ready, VEC[v][4]);
      chk("R4/R5/R7", $sformatf("ret_valid row %0d", v), ret_valid, VEC[v][3:0]);
      for (int i = 0; i < WIDTH; i++) begin
        if (VEC[v][i]) begin
          chk("R5", "ret_tag", ret_tag[i*TW +: TW], bhead + TW'(i));
          chk("R6", "ret_dst", ret_dst[i*RW +: RW], dst_of(bhead + TW'(i)));
          chk("R6", "ret_has_dst", ret_has_dst[i], has_of(bhead + TW'(i)));
        end
      end
      if (VEC[v][14] && alloc_ready && VEC[v][13:11] != 3'd0) begin
        chk("R2", "alloc_tag lane0", alloc_tag[TW-1:0], btail);
        chk("R2", "alloc_tag lane3", alloc_tag[3*TW +: TW], btail + TW'(3));
      end
      if (VEC[v][14] && alloc_ready) btail = btail + TW'(VEC[v][13:11]);
      if (VEC[v][5]) bhead = bhead + TW'($countones(VEC[v][3:0]));
    end

    // R1: reset in the middle of a run empties the buffer
    @(negedge clk);
    drive_bundle(1'b0, 3'd4);
    wb_valid = '0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    btail = '0;
    bhead = '0;
    #2;
    chk("R1", "ret_valid after reset", ret_valid, '0);
    chk("R1", "alloc_tag after reset", alloc_tag, {4'd3, 4'd2, 4'd1, 4'd0});

    // R4: two ports complete in the same cycle
    @(negedge clk);
    drive_bundle(1'b1, 3'd2);
    @(negedge clk);
    btail = btail + TW'(2);
    drive_bundle(1'b0, 3'd0);
    wb_valid = 2'b11;
    wb_tag   = {4'd0, 4'd1};
    #2;
    chk("R4", "ret_valid before wb edge", ret_valid, 4'b0000);
    @(negedge clk);
    wb_valid = '0;
    ret_ready = 1'b1;
    #2;
    chk("R4", "ret_valid after dual wb", ret_valid, 4'b0011);
    chk("R6", "ret_has_dst lane0", ret_has_dst[0], has_of(4'd0));
    @(negedge clk);
    #2;
    chk("R5", "ret_valid after drain", ret_valid, 4'b0000);
    drive_bundle(1'b0, 3'd4);
    #2;
    chk("R2", "next tag after drain", alloc_tag[TW-1:0], 4'd2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule